// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block runs the digital half of a successive-approximation analog-to-digital conversion. It drives a trial code to an external DAC and reads back one comparator bit. That bit is high when the sampled input is strictly above the DAC voltage. A single start pulse begins a binary search. The search tests one bit per clock, from the most significant bit down to the least significant bit. Each bit is kept or dropped based on the comparator answer.

After the final bit has been decided, the finished word is copied into a separate output register and a one-cycle completion pulse is raised. The trial register drives only the DAC and never the result port, so the result seen by downstream logic changes only when a conversion completes. The conversion width is a parameter. An N-bit conversion always takes N comparison cycles, whatever the input value.

Top module: `sar_ctrl`

## Requirements
- R1: While `rst_ni` is low, `dac_code_o`, `result_o`, `busy_o` and `done_o` are all zero.
- R2: A `start_i` pulse sampled while idle sets `busy_o`. From the next cycle, `dac_code_o` equals the half-scale code: only bit N-1 is set.
- R3: In each conversion cycle, exactly one bit is under test. If `cmp_gt_i` is 1, that bit stays 1. If `cmp_gt_i` is 0, the bit is cleared to 0. This includes the case where the input equals the DAC level.
- R4: After a bit is decided, the next lower bit is set to 1 on the next cycle and the already decided upper bits hold. For N=4 with a comparator that sees 3.7 V against a 4.8 V full scale, the trial codes are 8, 12, 14, 13 and the result is 12.
- R5: `done_o` is high in the cycle that follows exactly N clock edges after the edge that accepted `start_i`. For an input level L in DAC steps, `result_o` then equals 0 if L is 0, and min(L-1, 2^N-1) otherwise.
- R6: `done_o` is a single-cycle pulse, and `busy_o` is low in the cycle where `done_o` is high.
- R7: A `start_i` pulse received while `busy_o` is high is ignored: the running conversion keeps its timing and result, and no extra completion pulse follows.
- R8: `result_o` changes only in a cycle where `done_o` is high. During a conversion it holds the previous result.
- R9: The width N is a parameter with a default of 8, and N must be at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a conversion; only sampled while idle |
| cmp_gt_i | input | 1 | Comparator: 1 when the input is above the DAC output |
| dac_code_o | output | N | Trial code driven to the DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| result_o | output | N | Last completed conversion word |

## Verification
The assertions assume that `cmp_gt_i` is a combinational function of `dac_code_o` and of an input level that stays constant for the whole conversion. In other words, the sample-and-hold is modelled as ideal. The bench meets this assumption by setting the level before the start pulse and leaving it unchanged until the completion pulse is seen. It derives the comparator with a continuous strict greater-than against the code. The bench also presents spurious start pulses only while a conversion is running, and it never starts a new conversion in the cycle of a completion pulse.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    S_IDLE = 1'b0,
    S_CONV = 1'b1
  } sar_state_e;
endpackage

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  output logic         busy_o,
  output logic         accept_o,
  output logic         last_o,
  output logic [N-1:0] mask_o
);
  import sar_pkg::*;

  localparam logic [N-1:0] MSB_MASK = {1'b1, {(N-1){1'b0}}};

  sar_state_e   state_q, state_d;
  logic [N-1:0] mask_q, mask_d;

  assign accept_o = (state_q == S_IDLE) && start_i;
  assign last_o   = (state_q == S_CONV) && mask_q[0];
  assign busy_o   = (state_q == S_CONV);
  assign mask_o   = mask_q;

  always_comb begin
    state_d = state_q;
    mask_d  = mask_q;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d = S_CONV;
        mask_d  = MSB_MASK;
      end
      S_CONV: begin
        mask_d = mask_q >> 1;
        if (mask_q[0]) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      mask_q  <= mask_d;
    end
  end

  // R4: exactly one bit under test while converting
  p_mask_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $onehot(mask_o));

  // R7: a running conversion only walks down, never restarts
  p_no_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mask_o[0]) |=> (busy_o && mask_o == ($past(mask_o) >> 1)));
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         accept_i,
  input  logic         busy_i,
  input  logic         cmp_gt_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] code_o,
  output logic [N-1:0] decided_o
);
  localparam logic [N-1:0] MSB_MASK = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] code_q;

  // bit under test resolved by the comparator, other bits untouched
  assign decided_o = (code_q & ~mask_i) | (cmp_gt_i ? mask_i : '0);
  assign code_o    = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       code_q <= '0;
    else if (accept_i) code_q <= MSB_MASK;
    else if (busy_i)   code_q <= decided_o | (mask_i >> 1);
  end

  // R3: kept when comparator high
  p_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && cmp_gt_i) |=> ((code_o & $past(mask_i)) != '0));

  // R3: cleared when comparator low (equal counts as not larger)
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !cmp_gt_i) |=> ((code_o & $past(mask_i)) == '0));
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N-1:0] word_i,
  output logic [N-1:0] result_o,
  output logic         done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= load_i;
      if (load_i) result_o <= word_i;
    end
  end

  // R6: completion is a single pulse
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8: output word moves only with completion
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         cmp_gt_i,
  output logic [N-1:0] dac_code_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [N-1:0] result_o
);
  localparam logic [N-1:0] MSB_MASK = {1'b1, {(N-1){1'b0}}};

  logic         accept;
  logic         last;
  logic [N-1:0] mask;
  logic [N-1:0] decided;

  sar_seq #(.N(N)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy_o),
    .accept_o(accept),
    .last_o  (last),
    .mask_o  (mask)
  );

  sar_trial #(.N(N)) i_trial (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .busy_i   (busy_o),
    .cmp_gt_i (cmp_gt_i),
    .mask_i   (mask),
    .code_o   (dac_code_o),
    .decided_o(decided)
  );

  sar_result #(.N(N)) i_result (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (last),
    .word_i  (decided),
    .result_o(result_o),
    .done_o  (done_o)
  );

  // R2: first trial is half scale
  p_first_trial_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (dac_code_o == MSB_MASK));

  // R6: not busy while completing
  p_idle_at_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/test_sar_ctrl.sv
module test_sar_ctrl;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start8 = 1'b0;
  logic         start4 = 1'b0;
  int           level8 = 0;
  logic [N-1:0] dac8, res8;
  logic [3:0]   dac4, res4;
  logic         busy8, done8, busy4, done4;
  logic         cmp8, cmp4;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  int exp_res[$];
  int exp_cyc[$];
  int last_res = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // ideal DAC + comparator, strict greater-than
  assign cmp8 = level8 > int'(dac8);
  assign cmp4 = (3700 * 16) > (int'(dac4) * 4800);

  sar_ctrl #(.N(N)) i_sar_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start8), .cmp_gt_i(cmp8),
    .dac_code_o(dac8), .busy_o(busy8), .done_o(done8), .result_o(res8)
  );

  sar_ctrl #(.N(4)) i_sar_ctrl_w4 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start4), .cmp_gt_i(cmp4),
    .dac_code_o(dac4), .busy_o(busy4), .done_o(done4), .result_o(res4)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(input int l);
    if (l <= 0) return 0;
    if (l - 1 > (1 << N) - 1) return (1 << N) - 1;
    return l - 1;
  endfunction

  // driver: pushes expectations, optionally adds an ignored start
  task automatic convert(input int l, input bit glitch);
    @(negedge clk);
    level8 = l;
    start8 = 1'b1;
    exp_res.push_back(model(l));
    exp_cyc.push_back(cyc + 1 + N);
    @(negedge clk);
    start8 = 1'b0;
    check(busy8 == 1'b1, "R2 busy", busy8, 1);
    check(dac8 == (1 << (N - 1)), "R2 first trial", dac8, 1 << (N - 1));
    if (glitch) begin
      repeat (2) @(negedge clk);
      start8 = 1'b1;             // R7: must be ignored
      @(negedge clk);
      start8 = 1'b0;
    end
    wait (exp_res.size() == 0);
    @(negedge clk);
    check(busy8 == 1'b0 && done8 == 1'b0, "R6 idle after done", busy8, 0);
  endtask

  // monitor: scoreboard pop on every completion
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done8) begin
        check(busy8 == 1'b0, "R6 busy low at done", busy8, 0);
        if (exp_res.size() == 0) begin
          check(1'b0, "R7 unexpected done", 1, 0);
        end else begin
          int er, ec;
          er = exp_res.pop_front();
          ec = exp_cyc.pop_front();
          check(int'(res8) == er, "R5 result", res8, er);
          check(cyc == ec, "R5 latency", cyc, ec);
          last_res = er;
        end
      end else if (busy8) begin
        check(int'(res8) == last_res, "R8 result held", res8, last_res);
      end
    end
  end

  initial begin
    #1;
    check(dac8 == 0 && res8 == 0, "R1 reset data", dac8 | res8, 0);
    check(busy8 == 0 && done8 == 0, "R1 reset flags", busy8 | done8, 0);
    repeat (3) @(negedge clk);
    check(dac8 == 0 && res8 == 0 && busy8 == 0 && done8 == 0, "R1 reset hold", dac8, 0);
    rst_n = 1'b1;
    @(negedge clk);

    convert(0, 0);     // R3 all cleared
    convert(1, 0);     // R3 equal at code 1 clears
    convert(128, 0);   // R3 equal at half scale clears MSB
    convert(129, 0);
    convert(255, 0);
    convert(256, 0);   // R5 full scale
    convert(300, 0);
    convert(77, 1);    // R7 ignored start
    convert(200, 1);
    convert(1000, 0);

    // R4 worked example on the 4-bit instance, R9 width parameter
    begin
      int seq_exp[4] = '{8, 12, 14, 13};
      @(negedge clk);
      start4 = 1'b1;
      @(negedge clk);
      start4 = 1'b0;
      for (int i = 0; i < 4; i++) begin
        check(int'(dac4) == seq_exp[i], "R4 trial sequence", dac4, seq_exp[i]);
        @(negedge clk);
      end
      check(done4 == 1'b1, "R9 four-bit done", done4, 1);
      check(int'(res4) == 12, "R4 example result", res4, 12);
    end

    repeat (5) @(negedge clk);
    check(exp_res.size() == 0, "R7 no pending", exp_res.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule